// File: doc/BRIEF.md
# SDRAM Row-Open and Burst-Read Sequencer

This block sits on the controller side of an SDRAM channel. It turns single read requests from a host into device commands and collects the data burst that comes back. A request gives a bank, a row, a column and a flag that asks the device to close the row on its own once the burst ends. The sequencer remembers which banks have a row open. A request to a bank that is already open goes straight to the column read. Any other request first opens the row with an ACTIVE command and then waits out the row-to-column delay on NOP cycles before it sends the READ.

The timing limits are given in picoseconds and are converted at elaboration to clock counts, rounded up. The same holds for the clock period. CAS latency and burst length are parameters that must match the device's mode setting. After a READ the sequencer is free at once for the next request. So an ACTIVE to another bank can go out while the earlier burst is still on the data pins. Two ACTIVE commands are always kept at least the activate-to-activate spacing apart. Two READs are kept at least one burst length apart, so that their bursts never collide.

Top module: `sdrd_read_seq`

## Requirements
- R1: A READ that follows an ACTIVE of its own request appears exactly max(ACTIVE cycle + TRCD_CK, previous READ cycle + BL). TRCD_CK is ceil(TRCD_PS / TCK_PS). With the defaults TRCD_CK is 3: ACTIVE, NOP, NOP, READ.
- R2: A request that needs a row opened gets its ACTIVE exactly at max(accept cycle + 2, previous ACTIVE + TRRD_CK, bank release cycle). TRRD_CK is ceil(TRRD_PS / TCK_PS). Two ACTIVEs are never closer than TRRD_CK cycles.
- R3: ACTIVE carries the request's bank on sd_ba and its row on sd_addr. READ carries the bank on sd_ba and the column on sd_addr. Column bits below bit 10 sit at the same positions. Column bits from 10 upward move up by one place, so bit 10 is skipped. Address bit 10 is the auto-close flag: 1 closes the row, 0 keeps it open.
- R4: Commands are driven as {cs_n, ras_n, cas_n, we_n}: ACTIVE = 0011, READ = 0101, NOP = 0111. No other code is driven, and sd_cke is always 1.
- R5: For a READ seen in cycle n, word i of the burst (i = 0..BL-1) is sampled from sd_dq_i at the clock edge CL+i after the READ reaches the device. That word appears on rd_data with rd_valid high in cycle n+CL+1+i. rd_done is high only in cycle n+CL+BL, together with the last word.
- R6: A request to a bank whose row is open sends no ACTIVE. Its READ appears at max(accept cycle + 2, previous READ + BL). No ACTIVE is ever sent to a bank that is already open.
- R7: A READ with the auto-close flag marks its bank as closed. A later request to that bank sends ACTIVE again, no earlier than cycle n+CL+BL+1.
- R8: req_ready is high exactly when no accepted request still waits for its READ. A request is taken when req_valid and req_ready are both high at a clock edge. Each accepted request yields exactly one READ, in the order accepted, and a request that is held back is never dropped.
- R9: Two READ commands are at least BL cycles apart.
- R10: During reset the command is NOP, rd_valid and rd_done are 0, and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_bank | input | $clog2(BANKS) | Requested bank |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Starting column |
| req_ap | input | 1 | Close the row after the burst |
| sd_cke | output | 1 | Clock enable, tied high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | $clog2(BANKS) | Bank select |
| sd_addr | output | ADDR_W | Multiplexed row / column address |
| sd_dq_i | input | DQ_W | Read data from the device |
| rd_valid | output | 1 | rd_data holds a burst word |
| rd_data | output | DQ_W | Captured burst word |
| rd_done | output | 1 | Last word of a burst |

## Verification
All due times are counted in cycles between falling edges, from the cycle in which the bench sees the command or the accept. A row-opening ACTIVE is due two cycles after the accept, later if the spacing or a bank release holds it back. A READ is due TRCD_CK cycles after its ACTIVE, later if the previous READ holds it back. Data word i is due on rd_data CL+1+i cycles after the READ, and rd_done with the last word. The bench works out each due cycle from its own model of open banks and of the last ACTIVE and READ times. It then checks equality at that exact cycle, not just a lower bound. It drives sd_dq_i only in the cycles the device would. Every output is sampled on the falling edge, half a period away from the edges at which the registers change.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_RD} seq_state_t;

  // Time in ps to clock count, rounded up, at least one cycle.
  function automatic int unsigned clk_from_ps(input int unsigned t_ps,
                                              input int unsigned tck_ps);
    int unsigned q;
    q = (t_ps + tck_ps - 1) / tck_ps;
    if (q == 0) q = 1;
    return q;
  endfunction

  // Column placed on the address pins, skipping the auto-close bit.
  function automatic logic [15:0] col_addr(input logic [15:0] col,
                                           input int unsigned col_w,
                                           input int unsigned ap_bit,
                                           input logic ap);
    logic [15:0] a;
    a = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < col_w) begin
        if (i < ap_bit) a[i] = col[i];
        else if (i + 1 < 16) a[i+1] = col[i];
      end
    end
    a[ap_bit] = ap;
    return a;
  endfunction

endpackage

// File: rtl/sdrd_gap_cnt.sv
module sdrd_gap_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] SAT = '1;

  // Cycles since the last restart; value 1 in the cycle right after it.
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= SAT;
    else if (restart)     cnt <= W'(1);
    else if (cnt != SAT)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdrd_bank_track.sv
module sdrd_bank_track #(
  parameter int CLOSE_CYC = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_set,
  input  logic rd_set,
  input  logic rd_ap,
  output logic open_o,
  output logic closing_o
);
  localparam int CW = $clog2(CLOSE_CYC + 1);

  logic [CW-1:0] close_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_o    <= 1'b0;
      close_cnt <= '0;
    end else begin
      if (act_set) open_o <= 1'b1;
      if (rd_set && rd_ap) begin
        open_o    <= 1'b0;
        close_cnt <= CW'(CLOSE_CYC);
      end else if (close_cnt != '0) begin
        close_cnt <= close_cnt - 1'b1;
      end
    end
  end

  assign closing_o = (close_cnt != '0);

  // R7
  open_closing_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_o && closing_o));

  // R7
  no_act_while_closing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_set |-> !closing_o);
endmodule

// File: rtl/sdrd_rd_capture.sv
module sdrd_rd_capture #(
  parameter int CL   = 3,
  parameter int BL   = 4,
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic [DQ_W-1:0] dq_i,
  output logic            rd_valid,
  output logic [DQ_W-1:0] rd_data,
  output logic            rd_done
);
  localparam int L = CL + BL;

  logic [L-1:0] pipe;
  logic         window;
  logic         last_word;

  assign window    = |pipe[L-1:CL];
  assign last_word = pipe[L-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe     <= '0;
      rd_valid <= 1'b0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe     <= {pipe[L-2:0], rd_issue};
      rd_valid <= window;
      rd_done  <= last_word;
      if (window) rd_data <= dq_i;
    end
  end

  // R5
  done_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> rd_valid);
endmodule

// File: rtl/sdrd_read_seq.sv
module sdrd_read_seq
  import sdrd_pkg::*;
#(
  parameter int BANKS   = 4,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int ADDR_W  = 13,
  parameter int AP_BIT  = 10,
  parameter int DQ_W    = 16,
  parameter int CL      = 3,
  parameter int BL      = 4,
  parameter int TCK_PS  = 7500,
  parameter int TRCD_PS = 20000,
  parameter int TRRD_PS = 15000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [COL_W-1:0]         req_col,
  input  logic                     req_ap,
  output logic                     sd_cke,
  output logic                     sd_cs_n,
  output logic                     sd_ras_n,
  output logic                     sd_cas_n,
  output logic                     sd_we_n,
  output logic [$clog2(BANKS)-1:0] sd_ba,
  output logic [ADDR_W-1:0]        sd_addr,
  input  logic [DQ_W-1:0]          sd_dq_i,
  output logic                     rd_valid,
  output logic [DQ_W-1:0]          rd_data,
  output logic                     rd_done
);
  localparam int BA_W    = $clog2(BANKS);
  localparam int CNT_W   = 8;
  localparam int TRCD_CK = int'(clk_from_ps(TRCD_PS, TCK_PS));
  localparam int TRRD_CK = int'(clk_from_ps(TRRD_PS, TCK_PS));
  localparam logic [CNT_W-1:0] TRCD_LIM = CNT_W'(TRCD_CK);
  localparam logic [CNT_W-1:0] TRRD_LIM = CNT_W'(TRRD_CK);
  localparam logic [CNT_W-1:0] BL_LIM   = CNT_W'(BL);

  seq_state_t        st;
  logic [BA_W-1:0]   q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic              q_ap;
  logic              q_hit;

  logic [CNT_W-1:0]  act_gap, rcd_cnt, rd_gap;
  logic [BANKS-1:0]  bank_open, bank_closing;
  logic              accept, act_ok, rd_ok, fire_act, fire_rd;
  logic [15:0]       rd_addr_full;
  logic [3:0]        cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign act_ok    = !bank_closing[q_bank] && (act_gap >= TRRD_LIM);
  assign rd_ok     = (q_hit || rcd_cnt >= TRCD_LIM) && (rd_gap >= BL_LIM);
  assign fire_act  = (st == S_ACT) && act_ok;
  assign fire_rd   = (st == S_RD) && rd_ok;
  assign rd_addr_full = col_addr(16'(q_col), COL_W, AP_BIT, q_ap);

  sdrd_gap_cnt #(.W(CNT_W)) u_act_gap (.clk(clk), .rst_n(rst_n), .restart(fire_act), .cnt(act_gap));
  sdrd_gap_cnt #(.W(CNT_W)) u_rcd_cnt (.clk(clk), .rst_n(rst_n), .restart(fire_act), .cnt(rcd_cnt));
  sdrd_gap_cnt #(.W(CNT_W)) u_rd_gap  (.clk(clk), .rst_n(rst_n), .restart(fire_rd),  .cnt(rd_gap));

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    sdrd_bank_track #(.CLOSE_CYC(CL + BL)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_set  (fire_act && (q_bank == BA_W'(g))),
      .rd_set   (fire_rd && (q_bank == BA_W'(g))),
      .rd_ap    (q_ap),
      .open_o   (bank_open[g]),
      .closing_o(bank_closing[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      q_bank <= '0;
      q_row  <= '0;
      q_col  <= '0;
      q_ap   <= 1'b0;
      q_hit  <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          q_bank <= req_bank;
          q_row  <= req_row;
          q_col  <= req_col;
          q_ap   <= req_ap;
          q_hit  <= bank_open[req_bank];
          st     <= bank_open[req_bank] ? S_RD : S_ACT;
        end
        S_ACT:  if (fire_act) st <= S_RD;
        S_RD:   if (fire_rd)  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
    end else if (fire_act) begin
      cmd_q  <= CMD_ACT;
      ba_q   <= q_bank;
      addr_q <= ADDR_W'(q_row);
    end else if (fire_rd) begin
      cmd_q  <= CMD_RD;
      ba_q   <= q_bank;
      addr_q <= rd_addr_full[ADDR_W-1:0];
    end else begin
      cmd_q  <= CMD_NOP;
    end
  end

  assign sd_cke   = 1'b1;
  assign sd_cs_n  = cmd_q[3];
  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];
  assign sd_ba    = ba_q;
  assign sd_addr  = addr_q;

  sdrd_rd_capture #(.CL(CL), .BL(BL), .DQ_W(DQ_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_issue(fire_rd),
    .dq_i    (sd_dq_i),
    .rd_valid(rd_valid),
    .rd_data (rd_data),
    .rd_done (rd_done)
  );

  // R6
  act_only_closed_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_act |-> !bank_open[q_bank]);

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_rd |=> req_ready);

  if (TRCD_CK > 1) begin : g_rcd_chk
    // R1
    act_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |=> (cmd_q != CMD_RD));
  end

  if (TRRD_CK > 1) begin : g_rrd_chk
    // R2
    act_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |=> (cmd_q != CMD_ACT));
  end

  if (BL > 1) begin : g_rd_chk
    // R9
    rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_RD) |=> (cmd_q != CMD_RD));
  end
endmodule

// File: tb/sdrd_read_seq_tb.sv
module sdrd_read_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BANKS   = 4;
  localparam int ROW_W   = 13;
  localparam int COL_W   = 10;
  localparam int ADDR_W  = 13;
  localparam int AP_BIT  = 10;
  localparam int DQ_W    = 16;
  localparam int CL      = 3;
  localparam int BL      = 4;
  localparam int TCK_PS  = 7500;
  localparam int TRCD_PS = 20000;
  localparam int TRRD_PS = 15000;
  localparam int TRCD_EXP = (TRCD_PS + TCK_PS - 1) / TCK_PS;
  localparam int TRRD_EXP = (TRRD_PS + TCK_PS - 1) / TCK_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ap = 1'b0;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [ADDR_W-1:0] sd_addr;
  logic [DQ_W-1:0] sd_dq = 16'hDEAD;
  logic rd_valid, rd_done;
  logic [DQ_W-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdrd_read_seq #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT),
    .DQ_W(DQ_W), .CL(CL), .BL(BL), .TCK_PS(TCK_PS), .TRCD_PS(TRCD_PS), .TRRD_PS(TRRD_PS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ap(req_ap),
    .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_i(sd_dq),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit run_mon = 0;

  typedef struct {
    int bank; int row; int col; bit ap; int acc; bit hit; bit act_seen; int act_cyc;
  } req_t;
  req_t pq[$];

  bit   mopen [BANKS];
  int   free_at [BANKS];
  int   last_act = -1000;
  int   last_rd  = -1000;
  int   reads_seen = 0;
  int   dones_seen = 0;
  bit   drv_v [64];
  logic [DQ_W-1:0] drv_d [64];
  bit   exp_v [64];
  logic [DQ_W-1:0] exp_d [64];
  bit   exp_dn [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Column spread over the address pins, bit AP_BIT carrying the close flag.
  function automatic int exp_col_pins(input int col, input bit ap);
    int low, high;
    low  = col % (1 << AP_BIT);
    high = col / (1 << AP_BIT);
    return low + high * (1 << (AP_BIT + 1)) + (ap ? (1 << AP_BIT) : 0);
  endfunction

  always @(negedge clk) begin
    if (run_mon) begin
      int slot;
      logic [3:0] cmd;
      cyc++;
      slot = cyc % 64;
      sd_dq = drv_v[slot] ? drv_d[slot] : 16'hDEAD;
      drv_v[slot] = 0;

      if (rd_valid || exp_v[slot]) begin
        chk(rd_valid == exp_v[slot], "R5 rd_valid", int'(rd_valid), int'(exp_v[slot]));
        if (exp_v[slot]) chk(rd_data == exp_d[slot], "R5 rd_data", int'(rd_data), int'(exp_d[slot]));
      end
      if (rd_done || exp_dn[slot])
        chk(rd_done == exp_dn[slot], "R5 rd_done", int'(rd_done), int'(exp_dn[slot]));
      if (rd_done) dones_seen++;
      exp_v[slot] = 0;
      exp_dn[slot] = 0;

      chk(sd_cke == 1'b1, "R4 cke high", int'(sd_cke), 1);
      cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

      if (cmd == 4'b0011) begin
        if (pq.size() == 0 || pq[0].hit || pq[0].act_seen) begin
          chk(0, "R6 ACTIVE not expected", int'(cmd), 4'b0111);
        end else begin
          int b, e;
          b = pq[0].bank;
          chk(int'(sd_ba) == b, "R3 ACTIVE bank", int'(sd_ba), b);
          chk(int'(sd_addr) == pq[0].row, "R3 ACTIVE row", int'(sd_addr), pq[0].row);
          chk(!mopen[b], "R6 ACTIVE to open bank", int'(mopen[b]), 0);
          chk(cyc - last_act >= TRRD_EXP, "R2 ACTIVE spacing", cyc - last_act, TRRD_EXP);
          e = mx(mx(pq[0].acc + 2, last_act + TRRD_EXP), free_at[b]);
          chk(cyc == e, (free_at[b] > pq[0].acc + 2) ? "R7 ACTIVE after close" : "R2 ACTIVE cycle", cyc, e);
          pq[0].act_seen = 1;
          pq[0].act_cyc = cyc;
          mopen[b] = 1;
          last_act = cyc;
        end
      end else if (cmd == 4'b0101) begin
        if (pq.size() == 0 || (!pq[0].hit && !pq[0].act_seen)) begin
          chk(0, "R6 READ without ACTIVE", int'(cmd), 4'b0011);
          if (pq.size() != 0) void'(pq.pop_front());
        end else begin
          int b, e, pins;
          b = pq[0].bank;
          pins = exp_col_pins(pq[0].col, pq[0].ap);
          chk(int'(sd_ba) == b, "R3 READ bank", int'(sd_ba), b);
          chk(int'(sd_addr) == pins, "R3 READ column/auto-close pins", int'(sd_addr), pins);
          chk(cyc - last_rd >= BL, "R9 READ spacing", cyc - last_rd, BL);
          if (pq[0].hit) begin
            e = mx(pq[0].acc + 2, last_rd + BL);
            chk(cyc == e, "R6 READ on open row", cyc, e);
          end else begin
            e = mx(pq[0].act_cyc + TRCD_EXP, last_rd + BL);
            chk(cyc == e, "R1 READ after row-to-column delay", cyc, e);
          end
          for (int i = 0; i < BL; i++) begin
            logic [DQ_W-1:0] w;
            w = DQ_W'(cyc * 16 + i) ^ 16'h5A3C;
            drv_v[(cyc + CL + i) % 64] = 1;
            drv_d[(cyc + CL + i) % 64] = w;
            exp_v[(cyc + CL + 1 + i) % 64] = 1;
            exp_d[(cyc + CL + 1 + i) % 64] = w;
          end
          exp_dn[(cyc + CL + BL) % 64] = 1;
          if (pq[0].ap) begin
            mopen[b] = 0;
            free_at[b] = cyc + CL + BL + 1;
          end
          last_rd = cyc;
          reads_seen++;
          void'(pq.pop_front());
        end
      end else begin
        chk(cmd == 4'b0111, "R4 command encoding", int'(cmd), 4'b0111);
      end

      chk(req_ready == (pq.size() == 0), "R8 ready", int'(req_ready), int'(pq.size() == 0));

      if (req_valid && req_ready) begin
        req_t r;
        r.bank = int'(req_bank); r.row = int'(req_row); r.col = int'(req_col);
        r.ap = req_ap; r.acc = cyc; r.hit = mopen[int'(req_bank)];
        r.act_seen = 0; r.act_cyc = 0;
        pq.push_back(r);
      end
    end
  end

  task automatic send(input int b, input int row, input int col, input bit ap);
    @(posedge clk); #1;
    req_bank = 2'(b); req_row = ROW_W'(row); req_col = COL_W'(col); req_ap = ap;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R8 actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < BANKS; i++) begin mopen[i] = 0; free_at[i] = -1000; end
    for (int i = 0; i < 64; i++) begin drv_v[i] = 0; exp_v[i] = 0; exp_dn[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R10 reset NOP",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 4'b0111);
    chk(rd_valid == 1'b0, "R10 reset rd_valid", int'(rd_valid), 0);
    chk(rd_done == 1'b0, "R10 reset rd_done", int'(rd_done), 0);
    chk(req_ready == 1'b1, "R10 reset ready", int'(req_ready), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    run_mon = 1;

    // Directed: cold open (R1), hit (R6), other bank during burst (R2),
    // close and reopen (R7), back-to-back banks.
    send(0, 13'h0ABC, 10'h155, 0);
    send(0, 13'h0ABC, 10'h2AA, 0);
    send(1, 13'h1F00, 10'h001, 0);
    send(0, 13'h0ABC, 10'h3FF, 1);
    send(0, 13'h0123, 10'h000, 0);
    send(2, 13'h1FFF, 10'h3FF, 1);
    send(3, 13'h0000, 10'h200, 1);
    send(2, 13'h0555, 10'h0F0, 0);

    for (int k = 0; k < 300; k++) begin
      send(int'($urandom % 4), int'($urandom % 8192), int'($urandom % 1024), ($urandom % 4) == 0);
      repeat ($urandom % 5) @(posedge clk);
    end

    while (pq.size() != 0) @(posedge clk);
    repeat (CL + BL + 6) @(posedge clk);
    @(negedge clk);
    chk(dones_seen == reads_seen, "R5 one done per READ", dones_seen, reads_seen);
    chk(TRCD_EXP == 3, "R1 default delay count", TRCD_EXP, 3);
    summary();
    $finish;
  end
endmodule